// File: doc/BRIEF.md
# Delayed Lockstep Output Comparator

This block watches two identical cores that run the same instruction stream in delayed lockstep. The primary core takes the system inputs directly. The block holds those inputs back by a fixed skew of two cycles and hands them to the checker core. The checker therefore executes every instruction two cycles after the primary. A disturbance that reaches both cores at the same moment then lands on different instructions in each, and the two output streams differ.

Each cycle, the block delays the primary core's output bus (address, write data, write enable, byte strobes) by the same skew. It compares that delayed bus bit for bit against the checker's live output bus. Any difference sets a sticky error flag and drives a level interrupt toward software. A capture register records the cycle number and the bitwise difference of the first mismatch. Software reads the capture, clears the flag with a write-one-to-clear pulse, and decides how to recover.

A fault-injection input flips one chosen bit of the checker bus for a single cycle. This lets the detection path be proven end to end.

Top module: `lockstep_cmp`

## Requirements
- R1: `chk_in_o` equals the value `pri_in` had two cycles earlier. It is zero for the first two cycles after reset release.
- R2: Each cycle, the primary bus from two cycles earlier is compared bitwise against the current checker bus. Both buses are packed as {addr, wdata, we, strb}, so the strobes occupy the least significant bits, `we` sits just above them, then `wdata`, with `addr` on top.
- R3: A difference seen in cycle t sets `err_flag` at the clock edge that ends cycle t, so the flag reads high in cycle t+1.
- R4: Differences in the first two cycles after reset release are ignored and do not set the flag.
- R5: `err_flag` stays set until `err_clr` is high for a cycle. In a clear cycle without a new difference, the flag and the capture return to zero. In a clear cycle with a new difference, the flag stays set and the capture reloads with the new difference.
- R6: `irq` is high exactly when `err_flag` is high.
- R7: On the first difference, `cap_cycle` takes the cycle count and `cap_diff` takes the XOR of the two buses. The count is zero in the first cycle after reset release, increases by one each cycle and wraps. Later differences leave the capture unchanged until it is cleared.
- R8: While `inj_en` is high, bit `inj_sel` of the checker bus is inverted before comparison for that cycle. A selector at or beyond the bus width has no effect.
- R9: During and right after reset, `err_flag`, `irq`, `cap_cycle`, `cap_diff` and `chk_in_o` are zero.
- R10: A disturbance that alters both cores' outputs identically in the same cycle is still detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_in | input | IN_W | Inputs fed to the primary core |
| chk_in_o | output | IN_W | Same inputs, delayed by the skew, for the checker core |
| pri_addr | input | ADDR_W | Primary core address |
| pri_wdata | input | DATA_W | Primary core write data |
| pri_we | input | 1 | Primary core write enable |
| pri_strb | input | DATA_W/8 | Primary core byte strobes |
| chk_addr | input | ADDR_W | Checker core address |
| chk_wdata | input | DATA_W | Checker core write data |
| chk_we | input | 1 | Checker core write enable |
| chk_strb | input | DATA_W/8 | Checker core byte strobes |
| inj_en | input | 1 | Invert one checker bus bit this cycle |
| inj_sel | input | clog2(bus width) | Index of the bit to invert |
| err_clr | input | 1 | Write-one-to-clear for flag and capture |
| err_flag | output | 1 | Sticky mismatch flag |
| irq | output | 1 | Level interrupt request |
| cap_cycle | output | CNT_W | Cycle count of the first mismatch |
| cap_diff | output | bus width | Bitwise difference of the first mismatch |

## Verification
The bench builds the block with 16-bit address and data and an 8-bit input bus, giving a 35-bit compared bus and a 6-bit selector. Selector values 35 to 63 are therefore available to exercise the out-of-range case of injection. The cycle counter is built 8 bits wide, so a run of a few hundred cycles carries it past its wrap point before a capture. The skew stays at two, which matches the fixed two-cycle history the model keeps.

// File: rtl/lockstep_pkg.sv
// Package: shared defaults and width helpers for the lockstep comparator.
// Assumes the data bus is a whole number of bytes wide.
package lockstep_pkg;

    localparam int unsigned LS_SKEW   = 2;
    localparam int unsigned LS_ADDR_W = 32;
    localparam int unsigned LS_DATA_W = 32;
    localparam int unsigned LS_IN_W   = 32;
    localparam int unsigned LS_CNT_W  = 32;

    // Width of the packed {addr, wdata, we, strb} bus.
    function automatic int unsigned ls_bus_width(input int unsigned aw, input int unsigned dw);
        return aw + dw + 1 + dw / 8;
    endfunction

endpackage

// File: rtl/ls_delay_line.sv
// Module: fixed-depth register pipeline with synchronous zeroing reset.
// Assumes DEPTH >= 1; dout presents din from DEPTH cycles earlier.
module ls_delay_line #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [DEPTH];

    // Shift the pipeline by one stage every cycle; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < DEPTH; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/ls_compare.sv
// Module: bitwise comparator with single-bit fault injection on the checker side.
// Assumes ref_bus and chk_bus already belong to the same instruction; cmp_en
// gates the result while the delay pipelines still hold reset values.
module ls_compare #(
    parameter int unsigned BUS_W = 35,
    localparam int unsigned SEL_W = $clog2(BUS_W)
) (
    input  logic             cmp_en,
    input  logic [BUS_W-1:0] ref_bus,
    input  logic [BUS_W-1:0] chk_bus,
    input  logic             inj_en,
    input  logic [SEL_W-1:0] inj_sel,
    output logic [BUS_W-1:0] diff,
    output logic             mismatch
);

    logic [BUS_W-1:0] inj_mask;
    logic [BUS_W-1:0] chk_eff;

    // One decoder slice per bus bit; selectors past the top match nothing.
    for (genvar i = 0; i < BUS_W; i++) begin : g_inj
        assign inj_mask[i] = inj_en && (inj_sel == SEL_W'(i));
    end

    // Apply the injection mask and form the gated difference.
    always_comb begin
        chk_eff  = chk_bus ^ inj_mask;
        diff     = ref_bus ^ chk_eff;
        mismatch = cmp_en && (diff != '0);
    end

endmodule

// File: rtl/ls_fault_latch.sv
// Module: sticky mismatch flag, cycle counter and first-mismatch capture.
// Assumes a one-cycle clear pulse; a mismatch in the clear cycle wins over the clear.
module ls_fault_latch #(
    parameter int unsigned BUS_W = 35,
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mismatch,
    input  logic [BUS_W-1:0] diff,
    input  logic             clr,
    output logic             flag,
    output logic [CNT_W-1:0] cap_cycle,
    output logic [BUS_W-1:0] cap_diff
);

    logic [CNT_W-1:0] cyc_q;
    logic             load;

    // Free-running cycle count since reset release, wrapping at its width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Capture loads on a first mismatch, or on any mismatch in a clear cycle.
    always_comb begin
        load = mismatch && (clr || !flag);
    end

    // Sticky flag: set by mismatch, released only by a clear without mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (clr) begin
            flag <= mismatch;
        end else if (mismatch) begin
            flag <= 1'b1;
        end
    end

    // Capture register: holds the first mismatch until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_cycle <= '0;
            cap_diff  <= '0;
        end else if (load) begin
            cap_cycle <= cyc_q;
            cap_diff  <= diff;
        end else if (clr) begin
            cap_cycle <= '0;
            cap_diff  <= '0;
        end
    end

endmodule

// File: rtl/lockstep_cmp.sv
// Module: top of the delayed lockstep comparator.
// Delays the primary inputs toward the checker core and the primary outputs
// toward the comparator by SKEW cycles, then latches any difference.
// Assumes both cores are identical and deterministic for identical inputs.
module lockstep_cmp
    import lockstep_pkg::*;
#(
    parameter int unsigned ADDR_W = LS_ADDR_W,
    parameter int unsigned DATA_W = LS_DATA_W,
    parameter int unsigned IN_W   = LS_IN_W,
    parameter int unsigned CNT_W  = LS_CNT_W,
    parameter int unsigned SKEW   = LS_SKEW,
    localparam int unsigned STRB_W = DATA_W / 8,
    localparam int unsigned BUS_W  = ls_bus_width(ADDR_W, DATA_W),
    localparam int unsigned SEL_W  = $clog2(BUS_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   pri_in,
    output logic [IN_W-1:0]   chk_in_o,
    input  logic [ADDR_W-1:0] pri_addr,
    input  logic [DATA_W-1:0] pri_wdata,
    input  logic              pri_we,
    input  logic [STRB_W-1:0] pri_strb,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [DATA_W-1:0] chk_wdata,
    input  logic              chk_we,
    input  logic [STRB_W-1:0] chk_strb,
    input  logic              inj_en,
    input  logic [SEL_W-1:0]  inj_sel,
    input  logic              err_clr,
    output logic              err_flag,
    output logic              irq,
    output logic [CNT_W-1:0]  cap_cycle,
    output logic [BUS_W-1:0]  cap_diff
);

    logic [BUS_W-1:0] pri_bus;
    logic [BUS_W-1:0] pri_bus_dly;
    logic [BUS_W-1:0] chk_bus;
    logic [BUS_W-1:0] cmp_diff;
    logic             cmp_mis;
    logic             pipe_valid;

    // Pack both output buses with strobes at the low end.
    always_comb begin
        pri_bus = {pri_addr, pri_wdata, pri_we, pri_strb};
        chk_bus = {chk_addr, chk_wdata, chk_we, chk_strb};
    end

    ls_delay_line #(.WIDTH(IN_W), .DEPTH(SKEW)) u_in_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pri_in),
        .dout (chk_in_o)
    );

    ls_delay_line #(.WIDTH(BUS_W), .DEPTH(SKEW)) u_out_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pri_bus),
        .dout (pri_bus_dly)
    );

    ls_delay_line #(.WIDTH(1), .DEPTH(SKEW)) u_vld_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (1'b1),
        .dout (pipe_valid)
    );

    ls_compare #(.BUS_W(BUS_W)) u_cmp (
        .cmp_en  (pipe_valid),
        .ref_bus (pri_bus_dly),
        .chk_bus (chk_bus),
        .inj_en  (inj_en),
        .inj_sel (inj_sel),
        .diff    (cmp_diff),
        .mismatch(cmp_mis)
    );

    ls_fault_latch #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .mismatch (cmp_mis),
        .diff     (cmp_diff),
        .clr      (err_clr),
        .flag     (err_flag),
        .cap_cycle(cap_cycle),
        .cap_diff (cap_diff)
    );

    assign irq = err_flag;

endmodule

// File: rtl/lockstep_cmp_sva.sv
// Module: property checker for lockstep_cmp, attached with bind below.
// Keeps its own count of cycles since reset release to bound history lookups.
module lockstep_cmp_sva #(
    parameter int unsigned IN_W  = 32,
    parameter int unsigned BUS_W = 69,
    parameter int unsigned CNT_W = 32,
    parameter int unsigned SKEW  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IN_W-1:0]  pri_in,
    input logic [IN_W-1:0]  chk_in_o,
    input logic             err_clr,
    input logic             err_flag,
    input logic             irq,
    input logic [CNT_W-1:0] cap_cycle,
    input logic [BUS_W-1:0] cap_diff
);

    logic [1:0] since_q;

    // Saturating count of clock edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (since_q != 2'd3) begin
            since_q <= since_q + 2'd1;
        end
    end

    if (SKEW == 2) begin : g_skew2
        a_r1_input_skew: assert property (@(posedge clk) disable iff (!rst_n)
            (since_q >= 2'd2) |-> (chk_in_o == $past(pri_in, 2)));
    end

    a_r4_masked_start: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q < 2'd2) |=> !err_flag);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == err_flag);

    a_r7_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> ($stable(cap_cycle) && $stable(cap_diff)));

    a_r3_flag_has_diff: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (cap_diff != '0));

endmodule

bind lockstep_cmp lockstep_cmp_sva #(
    .IN_W (IN_W),
    .BUS_W(BUS_W),
    .CNT_W(CNT_W),
    .SKEW (SKEW)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .pri_in   (pri_in),
    .chk_in_o (chk_in_o),
    .err_clr  (err_clr),
    .err_flag (err_flag),
    .irq      (irq),
    .cap_cycle(cap_cycle),
    .cap_diff (cap_diff)
);

// File: tb/lockstep_cmp_bench.sv
// Bench: scoreboard for lockstep_cmp. A driver task models both cores and the
// expected flag/capture state and queues one expectation per cycle; a monitor
// pops them at the falling edge and compares against the ports.
module lockstep_cmp_bench;

    localparam int BW = 35;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pri_in = '0;
    logic [7:0]  chk_in_o;
    logic [15:0] pri_addr = '0, chk_addr = '0;
    logic [15:0] pri_wdata = '0, chk_wdata = '0;
    logic        pri_we = 1'b0, chk_we = 1'b0;
    logic [1:0]  pri_strb = '0, chk_strb = '0;
    logic        inj_en = 1'b0;
    logic [5:0]  inj_sel = '0;
    logic        err_clr = 1'b0;
    logic        err_flag, irq;
    logic [7:0]  cap_cycle;
    logic [BW-1:0] cap_diff;

    lockstep_cmp #(.ADDR_W(16), .DATA_W(16), .IN_W(8), .CNT_W(8)) u_lockstep_cmp (
        .clk(clk), .rst_n(rst_n), .pri_in(pri_in), .chk_in_o(chk_in_o),
        .pri_addr(pri_addr), .pri_wdata(pri_wdata), .pri_we(pri_we), .pri_strb(pri_strb),
        .chk_addr(chk_addr), .chk_wdata(chk_wdata), .chk_we(chk_we), .chk_strb(chk_strb),
        .inj_en(inj_en), .inj_sel(inj_sel), .err_clr(err_clr),
        .err_flag(err_flag), .irq(irq), .cap_cycle(cap_cycle), .cap_diff(cap_diff)
    );

    always #2 clk = ~clk;

    typedef struct {
        int            at;
        logic [7:0]    cin;
        logic          flag;
        logic [7:0]    ccyc;
        logic [BW-1:0] cdiff;
        string         req;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    int   cyc_n = 0;
    bit   done = 1'b0;

    // Bench model state.
    logic [7:0]    pinh0, pinh1;
    logic [BW-1:0] ph0, ph1;
    int            idx;
    logic          mf;
    logic [7:0]    mcyc, mcnt;
    logic [BW-1:0] mdiff;

    // Core model: a deterministic function of its input.
    function automatic logic [BW-1:0] core(input logic [7:0] x);
        return {x, ~x, x ^ 8'h5A, x + 8'd3, x[0], x[2:1]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Count rising edges.
    always @(posedge clk) cyc_n <= cyc_n + 1;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc_n, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Monitor: compare the ports against the expectation queued for this cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at == cyc_n) begin
            exp_t e;
            e = q.pop_front();
            check("R1", "chk_in_o", 64'(chk_in_o), 64'(e.cin));
            check(e.req, "err_flag", 64'(err_flag), 64'(e.flag));
            check("R6", "irq", 64'(irq), 64'(e.flag));
            check("R7", "cap_cycle", 64'(cap_cycle), 64'(e.ccyc));
            check("R7", "cap_diff", 64'(cap_diff), 64'(e.cdiff));
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        inj_en = 1'b0;
        err_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check("R9", "reset err_flag", 64'(err_flag), 64'd0);
        check("R9", "reset irq", 64'(irq), 64'd0);
        check("R9", "reset cap_cycle", 64'(cap_cycle), 64'd0);
        check("R9", "reset cap_diff", 64'(cap_diff), 64'd0);
        check("R9", "reset chk_in_o", 64'(chk_in_o), 64'd0);
        pinh0 = '0; pinh1 = '0; ph0 = '0; ph1 = '0;
        idx = 0; mf = 1'b0; mcyc = '0; mcnt = '0; mdiff = '0;
    endtask

    // Driver: apply one cycle of stimulus, queue the expected next state.
    task automatic step(input logic [7:0] pin, input logic [BW-1:0] pflip,
                        input logic [BW-1:0] cflip, input logic ie,
                        input logic [5:0] isel, input logic clr, input string req);
        logic [BW-1:0] pbus, cbus, imask, diff;
        logic mis;
        exp_t e;
        pbus = core(pin) ^ pflip;
        cbus = core(pinh1) ^ cflip;
        pri_in = pin;
        {pri_addr, pri_wdata, pri_we, pri_strb} = pbus;
        {chk_addr, chk_wdata, chk_we, chk_strb} = cbus;
        inj_en = ie;
        inj_sel = isel;
        err_clr = clr;
        imask = (ie && isel < 6'(BW)) ? (BW'(1) << isel) : '0;
        diff = ph1 ^ cbus ^ imask;
        mis = (idx >= 2) && (diff != '0);
        if (clr) begin
            mf = mis;
            mcyc = mis ? mcnt : '0;
            mdiff = mis ? diff : '0;
        end else if (mis && !mf) begin
            mf = 1'b1;
            mcyc = mcnt;
            mdiff = diff;
        end
        e.at = cyc_n + 1;
        e.cin = pinh0;
        e.flag = mf;
        e.ccyc = mcyc;
        e.cdiff = mdiff;
        e.req = req;
        q.push_back(e);
        mcnt = mcnt + 8'd1;
        idx++;
        pinh1 = pinh0; pinh0 = pin;
        ph1 = ph0; ph0 = pbus;
        @(posedge clk);
        #1;
    endtask

    task automatic clean(input int n, input int seed, input string req);
        for (int k = 0; k < n; k++) begin
            step(8'(k * 37 + seed), '0, '0, 1'b0, '0, 1'b0, req);
        end
    endtask

    initial begin
        do_reset();
        // R4: garbage on the checker bus while the pipelines fill is ignored.
        step(8'h11, '0, BW'(7), 1'b0, '0, 1'b0, "R4");
        step(8'h22, '0, BW'(7), 1'b0, '0, 1'b0, "R4");
        // R2: identical streams with the skew never flag.
        clean(20, 5, "R2");
        // R3: upset on checker address bit 20 flags one cycle later.
        step(8'h3C, '0, BW'(1) << 20, 1'b0, '0, 1'b0, "R3");
        clean(3, 9, "R3");
        // R7: a later, different upset leaves the capture untouched.
        step(8'h44, '0, BW'(1) << 7, 1'b0, '0, 1'b0, "R7");
        clean(3, 1, "R7");
        // R5: clear without a new difference.
        step(8'h55, '0, '0, 1'b0, '0, 1'b1, "R5");
        clean(4, 2, "R5");
        // R8: inject on strobe bit 0, then on write enable (bit 2).
        step(8'h66, '0, '0, 1'b1, 6'd0, 1'b0, "R8");
        clean(2, 3, "R8");
        step(8'h67, '0, '0, 1'b0, '0, 1'b1, "R5");
        step(8'h68, '0, '0, 1'b1, 6'd2, 1'b0, "R8");
        clean(2, 4, "R8");
        // R5: clear in the same cycle as a new difference keeps the flag set.
        step(8'h69, '0, '0, 1'b1, 6'd34, 1'b1, "R5");
        clean(2, 6, "R5");
        step(8'h6A, '0, '0, 1'b0, '0, 1'b1, "R5");
        // R8: selector past the bus top does nothing.
        step(8'h6B, '0, '0, 1'b1, 6'd40, 1'b0, "R8");
        step(8'h6C, '0, '0, 1'b1, 6'd63, 1'b0, "R8");
        clean(3, 7, "R8");
        // R10: same disturbance on both cores in the same cycle.
        step(8'h70, BW'(1) << 5, BW'(1) << 5, 1'b0, '0, 1'b0, "R10");
        clean(4, 8, "R10");
        // R9: reset mid-run, then run past the counter wrap before an upset.
        do_reset();
        clean(270, 13, "R7");
        step(8'h81, '0, BW'(1) << 33, 1'b0, '0, 1'b0, "R7");
        clean(3, 14, "R3");
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule